// File: doc/BRIEF.md
# Floppy controller interrupt status arbiter

This block holds the interrupt bookkeeping of a floppy disk controller for up to four drives. Seek and recalibrate completions and drive ready-line changes come in as single-cycle event inputs. Each event marks its drive as pending and stores the status-register-0 byte for that drive. While any drive is pending, a single interrupt line to the host is raised. The host answers the interrupt with the Sense Interrupt command. Each such command reports the lowest-numbered pending drive: one byte of status register 0, then that drive's present cylinder. It then clears only that drive, so queued "hidden" interrupts are drained one per command.

The block also decides whether a command may start. A Sense Interrupt with nothing pending gets a one-byte invalid-command answer. After a seek or recalibrate completes, any command other than Sense Interrupt gets the same answer until a Sense Interrupt has been issued. Every other command is accepted with a one-cycle pulse and is left to the rest of the controller.

The sequencer has three states. `SQ_IDLE` waits for a command. `SQ_BYTE0` presents the first result byte. `SQ_BYTE1` presents the cylinder byte. The transitions are:
- SQ_IDLE to SQ_BYTE0 on a Sense Interrupt command.
- SQ_IDLE to SQ_BYTE0 on a command that is blocked.
- SQ_IDLE stays in SQ_IDLE on an accepted command.
- SQ_BYTE0 to SQ_BYTE1 when two bytes are due.
- SQ_BYTE0 to SQ_IDLE for a single-byte answer.
- SQ_BYTE1 to SQ_IDLE always.

Top module: `fdc_irq_arbiter`

## Requirements
- R1: A synchronous active-high reset clears all pending drives, the result output, the accept pulse and the seek lock. After reset, irq_o is 0 and a non-sense command is accepted.
- R2: A successful recalibrate of drive 0 followed by Sense Interrupt (opcode 0x08) returns 0x20 and then cylinder 0x00.
- R3: A seek or recalibrate completion flagged as not reaching its target reports bits 7:5 = 011, giving 0x60 | drive, plus the head and not-ready bits.
- R4: A ready-line change reports code 11 in bits 7:6 with bit 5 clear. Bit 3 is set when the drive is not ready, bits 1:0 hold the drive, and the cylinder byte is that drive's present cylinder. A change on a ready drive 1 reads 0xC1.
- R5: irq_o goes high in the cycle after any event. It stays high while any drive is pending and falls after the Sense Interrupt that clears the last pending drive.
- R6: With several drives pending, each Sense Interrupt reports the lowest-numbered one and clears only that drive.
- R7: A Sense Interrupt with nothing pending returns the single byte 0x80, marked as last.
- R8: After a seek or recalibrate completion, any non-sense opcode is answered with the single byte 0x80 and is not accepted. This repeats until a Sense Interrupt is issued.
- R9: A non-sense command with no lock gives a one-cycle cmd_accept_o in the next cycle and no result byte.
- R10: A successful seek reports 0x20 with bit 2 set to the head, bit 3 set when the drive is not ready and bits 1:0 set to the drive. The cylinder byte is the seek's target cylinder. A recalibrate sets the cylinder to 0.
- R11: The first result byte appears in the cycle after the command and the cylinder byte in the next cycle, the latter with res_last_o. Commands that arrive while a result is being presented are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_done_i | input | 1 | Seek or recalibrate finished this cycle |
| op_drive_i | input | 2 | Drive of the finished operation |
| op_fail_i | input | 1 | Target track not reached |
| op_recal_i | input | 1 | Finished operation was a recalibrate |
| op_head_i | input | 1 | Head selected by the operation |
| op_cyl_i | input | 8 | Target cylinder of a seek |
| rdy_chg_i | input | NDRV | Per-drive ready-line change pulse |
| rdy_i | input | NDRV | Per-drive ready level |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_op_i | input | 8 | Command opcode |
| cmd_accept_o | output | 1 | Command accepted, one-cycle pulse |
| res_valid_o | output | 1 | Result byte present |
| res_data_o | output | 8 | Result byte |
| res_last_o | output | 1 | Present byte is the final one |
| irq_o | output | 1 | Interrupt to host |

## Verification
The bench builds the block with its defaults: four drives and Sense Interrupt opcode 0x08. With four drives, every drive-number encoding in bits 1:0 can be reached. Simultaneous pending entries on non-adjacent drives can be set up, which exercises the lowest-first ordering. Drive 3 is also reached, the top slot of the priority picker.

// File: rtl/fdc_irq_pkg.sv
package fdc_irq_pkg;

    localparam int DRV_W  = 2;
    localparam int BYTE_W = 8;

    localparam logic [1:0] IC_NORMAL  = 2'b00;
    localparam logic [1:0] IC_ABNORM  = 2'b01;
    localparam logic [1:0] IC_INVALID = 2'b10;
    localparam logic [1:0] IC_RDYCHG  = 2'b11;

    localparam logic [BYTE_W-1:0] ST0_INVALID = {IC_INVALID, 6'b000000};

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_BYTE0,
        SQ_BYTE1
    } seq_state_e;

    typedef struct packed {
        logic [1:0]       code;
        logic             seek_end;
        logic             equip;
        logic             not_rdy;
        logic             head;
        logic [DRV_W-1:0] drive;
    } st0_t;

endpackage

// File: rtl/fdc_irq_flags.sv
module fdc_irq_flags
    import fdc_irq_pkg::*;
#(
    parameter int NDRV = 4
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               op_done,
    input  logic [DRV_W-1:0]                   op_drive,
    input  logic                               op_fail,
    input  logic                               op_recal,
    input  logic                               op_head,
    input  logic [BYTE_W-1:0]                  op_cyl,
    input  logic [NDRV-1:0]                    rdy_chg,
    input  logic [NDRV-1:0]                    rdy,
    input  logic                               clr_en,
    input  logic [DRV_W-1:0]                   clr_idx,
    output logic [NDRV-1:0]                    pend,
    output logic [NDRV-1:0][BYTE_W-1:0]        st0_q,
    output logic [NDRV-1:0][BYTE_W-1:0]        pcn_q
);

    for (genvar d = 0; d < NDRV; d++) begin : g_drv
        localparam logic [DRV_W-1:0] MY_IDX = DRV_W'(d);
        logic hit;
        logic clr_me;
        st0_t seek_st;
        st0_t chg_st;

        assign hit    = op_done && (op_drive == MY_IDX);
        assign clr_me = clr_en && (clr_idx == MY_IDX);

        always_comb begin
            seek_st          = '0;
            seek_st.code     = op_fail ? IC_ABNORM : IC_NORMAL;
            seek_st.seek_end = 1'b1;
            seek_st.not_rdy  = ~rdy[d];
            seek_st.head     = op_head;
            seek_st.drive    = MY_IDX;
            chg_st           = '0;
            chg_st.code      = IC_RDYCHG;
            chg_st.not_rdy   = ~rdy[d];
            chg_st.drive     = MY_IDX;
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                pend[d]  <= 1'b0;
                st0_q[d] <= '0;
                pcn_q[d] <= '0;
            end else if (hit) begin
                pend[d]  <= 1'b1;
                st0_q[d] <= seek_st;
                pcn_q[d] <= op_recal ? '0 : op_cyl;
            end else if (rdy_chg[d]) begin
                pend[d]  <= 1'b1;
                st0_q[d] <= chg_st;
            end else if (clr_me) begin
                pend[d]  <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/fdc_irq_pick.sv
module fdc_irq_pick
    import fdc_irq_pkg::*;
#(
    parameter int NDRV = 4
) (
    input  logic [NDRV-1:0]  pend,
    output logic             any,
    output logic [DRV_W-1:0] sel
);

    always_comb begin
        any = |pend;
        sel = '0;
        for (int i = NDRV - 1; i >= 0; i--) begin
            if (pend[i]) sel = DRV_W'(i);
        end
    end

endmodule

// File: rtl/fdc_irq_seq.sv
module fdc_irq_seq
    import fdc_irq_pkg::*;
#(
    parameter logic [7:0] SENSE_OP = 8'h08
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [7:0]        cmd_op,
    input  logic              op_done,
    input  logic              any,
    input  logic [DRV_W-1:0]  sel,
    input  logic [BYTE_W-1:0] sel_st0,
    input  logic [BYTE_W-1:0] sel_pcn,
    output logic              clr_en,
    output logic [DRV_W-1:0]  clr_idx,
    output logic              res_valid,
    output logic [BYTE_W-1:0] res_data,
    output logic              res_last,
    output logic              cmd_accept,
    output logic              lock
);

    seq_state_e        state_q, state_d;
    logic [BYTE_W-1:0] hold0_q, hold0_d, hold1_q, hold1_d;
    logic              two_q, two_d;
    logic              accept_q, accept_d;
    logic              lock_q, lock_d;
    logic              is_sense;

    assign is_sense = (cmd_op == SENSE_OP);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= SQ_IDLE;
            hold0_q  <= '0;
            hold1_q  <= '0;
            two_q    <= 1'b0;
            accept_q <= 1'b0;
            lock_q   <= 1'b0;
        end else begin
            state_q  <= state_d;
            hold0_q  <= hold0_d;
            hold1_q  <= hold1_d;
            two_q    <= two_d;
            accept_q <= accept_d;
            lock_q   <= lock_d;
        end
    end

    always_comb begin
        state_d  = state_q;
        hold0_d  = hold0_q;
        hold1_d  = hold1_q;
        two_d    = two_q;
        accept_d = 1'b0;
        lock_d   = lock_q;
        clr_en   = 1'b0;
        clr_idx  = sel;
        unique case (state_q)
            SQ_IDLE: begin
                if (cmd_valid) begin
                    if (is_sense) begin
                        lock_d  = 1'b0;
                        state_d = SQ_BYTE0;
                        if (any) begin
                            hold0_d = sel_st0;
                            hold1_d = sel_pcn;
                            two_d   = 1'b1;
                            clr_en  = 1'b1;
                        end else begin
                            hold0_d = ST0_INVALID;
                            two_d   = 1'b0;
                        end
                    end else if (lock_q) begin
                        hold0_d = ST0_INVALID;
                        two_d   = 1'b0;
                        state_d = SQ_BYTE0;
                    end else begin
                        accept_d = 1'b1;
                    end
                end
            end
            SQ_BYTE0: state_d = two_q ? SQ_BYTE1 : SQ_IDLE;
            SQ_BYTE1: state_d = SQ_IDLE;
            default:  state_d = SQ_IDLE;
        endcase
        if (op_done) lock_d = 1'b1;
    end

    always_comb begin
        res_valid  = 1'b0;
        res_data   = '0;
        res_last   = 1'b0;
        unique case (state_q)
            SQ_IDLE: ;
            SQ_BYTE0: begin
                res_valid = 1'b1;
                res_data  = hold0_q;
                res_last  = ~two_q;
            end
            SQ_BYTE1: begin
                res_valid = 1'b1;
                res_data  = hold1_q;
                res_last  = 1'b1;
            end
            default: ;
        endcase
        cmd_accept = accept_q;
        lock       = lock_q;
    end

endmodule

// File: rtl/fdc_irq_arbiter.sv
module fdc_irq_arbiter
    import fdc_irq_pkg::*;
#(
    parameter int         NDRV     = 4,
    parameter logic [7:0] SENSE_OP = 8'h08
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            op_done_i,
    input  logic [1:0]      op_drive_i,
    input  logic            op_fail_i,
    input  logic            op_recal_i,
    input  logic            op_head_i,
    input  logic [7:0]      op_cyl_i,
    input  logic [NDRV-1:0] rdy_chg_i,
    input  logic [NDRV-1:0] rdy_i,
    input  logic            cmd_valid_i,
    input  logic [7:0]      cmd_op_i,
    output logic            cmd_accept_o,
    output logic            res_valid_o,
    output logic [7:0]      res_data_o,
    output logic            res_last_o,
    output logic            irq_o
);

    logic [NDRV-1:0]             pend;
    logic [NDRV-1:0][BYTE_W-1:0] st0_q;
    logic [NDRV-1:0][BYTE_W-1:0] pcn_q;
    logic                        any;
    logic [DRV_W-1:0]            sel;
    logic                        clr_en;
    logic [DRV_W-1:0]            clr_idx;
    logic                        seek_lock;

    fdc_irq_flags #(.NDRV(NDRV)) u_flags (
        .clk      (clk),
        .rst      (rst),
        .op_done  (op_done_i),
        .op_drive (op_drive_i),
        .op_fail  (op_fail_i),
        .op_recal (op_recal_i),
        .op_head  (op_head_i),
        .op_cyl   (op_cyl_i),
        .rdy_chg  (rdy_chg_i),
        .rdy      (rdy_i),
        .clr_en   (clr_en),
        .clr_idx  (clr_idx),
        .pend     (pend),
        .st0_q    (st0_q),
        .pcn_q    (pcn_q)
    );

    fdc_irq_pick #(.NDRV(NDRV)) u_pick (
        .pend (pend),
        .any  (any),
        .sel  (sel)
    );

    fdc_irq_seq #(.SENSE_OP(SENSE_OP)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .cmd_valid  (cmd_valid_i),
        .cmd_op     (cmd_op_i),
        .op_done    (op_done_i),
        .any        (any),
        .sel        (sel),
        .sel_st0    (st0_q[sel]),
        .sel_pcn    (pcn_q[sel]),
        .clr_en     (clr_en),
        .clr_idx    (clr_idx),
        .res_valid  (res_valid_o),
        .res_data   (res_data_o),
        .res_last   (res_last_o),
        .cmd_accept (cmd_accept_o),
        .lock       (seek_lock)
    );

    assign irq_o = any;

endmodule

// File: rtl/fdc_irq_arbiter_chk.sv
module fdc_irq_arbiter_chk #(
    parameter int         NDRV     = 4,
    parameter logic [7:0] SENSE_OP = 8'h08
) (
    input logic            clk,
    input logic            rst,
    input logic            op_done_i,
    input logic [NDRV-1:0] rdy_chg_i,
    input logic            cmd_valid_i,
    input logic [7:0]      cmd_op_i,
    input logic            cmd_accept_o,
    input logic            res_valid_o,
    input logic [7:0]      res_data_o,
    input logic            res_last_o,
    input logic            irq_o,
    input logic            seek_lock
);

    a_r5_irq_follows_event: assert property (@(posedge clk) disable iff (rst)
        op_done_i |=> irq_o);

    a_r5_no_spurious_irq: assert property (@(posedge clk) disable iff (rst)
        (!irq_o && !op_done_i && !(|rdy_chg_i)) |=> !irq_o);

    a_r7_empty_sense_invalid: assert property (@(posedge clk) disable iff (rst)
        (!irq_o && cmd_valid_i && cmd_op_i == SENSE_OP && !res_valid_o)
        |=> (res_valid_o && res_data_o == 8'h80 && res_last_o));

    a_r8_lock_blocks_command: assert property (@(posedge clk) disable iff (rst)
        (seek_lock && cmd_valid_i && cmd_op_i != SENSE_OP && !res_valid_o)
        |=> (!cmd_accept_o && res_valid_o && res_data_o == 8'h80 && res_last_o));

    a_r9_accept_without_result: assert property (@(posedge clk) disable iff (rst)
        cmd_accept_o |-> !res_valid_o);

    a_r11_second_byte_last: assert property (@(posedge clk) disable iff (rst)
        (res_valid_o && !res_last_o) |=> (res_valid_o && res_last_o));

endmodule

bind fdc_irq_arbiter fdc_irq_arbiter_chk #(.NDRV(NDRV), .SENSE_OP(SENSE_OP)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .op_done_i    (op_done_i),
    .rdy_chg_i    (rdy_chg_i),
    .cmd_valid_i  (cmd_valid_i),
    .cmd_op_i     (cmd_op_i),
    .cmd_accept_o (cmd_accept_o),
    .res_valid_o  (res_valid_o),
    .res_data_o   (res_data_o),
    .res_last_o   (res_last_o),
    .irq_o        (irq_o),
    .seek_lock    (seek_lock)
);

// File: tb/fdc_irq_arbiter_test.sv
module fdc_irq_arbiter_test;

    localparam int         CLK_PERIOD = 10;
    localparam int         NDRV       = 4;
    localparam logic [7:0] SENSE      = 8'h08;
    localparam logic [7:0] OTHER      = 8'h0F;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            op_done_i = 1'b0;
    logic [1:0]      op_drive_i = '0;
    logic            op_fail_i = 1'b0;
    logic            op_recal_i = 1'b0;
    logic            op_head_i = 1'b0;
    logic [7:0]      op_cyl_i = '0;
    logic [NDRV-1:0] rdy_chg_i = '0;
    logic [NDRV-1:0] rdy_i = '1;
    logic            cmd_valid_i = 1'b0;
    logic [7:0]      cmd_op_i = '0;
    logic            cmd_accept_o;
    logic            res_valid_o;
    logic [7:0]      res_data_o;
    logic            res_last_o;
    logic            irq_o;

    int n_cmp = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fdc_irq_arbiter #(.NDRV(NDRV), .SENSE_OP(SENSE)) uut (
        .clk(clk), .rst(rst),
        .op_done_i(op_done_i), .op_drive_i(op_drive_i), .op_fail_i(op_fail_i),
        .op_recal_i(op_recal_i), .op_head_i(op_head_i), .op_cyl_i(op_cyl_i),
        .rdy_chg_i(rdy_chg_i), .rdy_i(rdy_i),
        .cmd_valid_i(cmd_valid_i), .cmd_op_i(cmd_op_i),
        .cmd_accept_o(cmd_accept_o), .res_valid_o(res_valid_o),
        .res_data_o(res_data_o), .res_last_o(res_last_o), .irq_o(irq_o)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic seek_evt(input logic [1:0] drv, input logic fail, input logic recal,
                            input logic head, input logic [7:0] cyl);
        @(negedge clk);
        op_done_i = 1'b1; op_drive_i = drv; op_fail_i = fail;
        op_recal_i = recal; op_head_i = head; op_cyl_i = cyl;
        @(negedge clk);
        op_done_i = 1'b0; op_fail_i = 1'b0; op_recal_i = 1'b0;
    endtask

    task automatic ready_evt(input int drv);
        @(negedge clk);
        rdy_chg_i[drv] = 1'b1;
        @(negedge clk);
        rdy_chg_i = '0;
    endtask

    task automatic issue(input logic [7:0] op);
        @(negedge clk);
        cmd_valid_i = 1'b1; cmd_op_i = op;
        @(negedge clk);
        cmd_valid_i = 1'b0;
    endtask

    task automatic sense_two(input string req, input logic [7:0] e0, input logic [7:0] e1);
        issue(SENSE);
        check({req, " byte0 valid"}, 8'(res_valid_o), 8'd1);
        check({req, " byte0"}, res_data_o, e0);
        check({req, " byte0 not last"}, 8'(res_last_o), 8'd0);
        @(negedge clk);
        check({req, " byte1"}, res_data_o, e1);
        check({req, " byte1 last"}, 8'(res_last_o & res_valid_o), 8'd1);
        @(negedge clk);
        check({req, " idle after"}, 8'(res_valid_o), 8'd0);
    endtask

    task automatic single_invalid(input string req, input logic [7:0] op);
        issue(op);
        check({req, " valid"}, 8'(res_valid_o), 8'd1);
        check({req, " code"}, res_data_o, 8'h80);
        check({req, " last"}, 8'(res_last_o), 8'd1);
        check({req, " no accept"}, 8'(cmd_accept_o), 8'd0);
        @(negedge clk);
        check({req, " idle after"}, 8'(res_valid_o), 8'd0);
    endtask

    task automatic t_reset;
        check("R1 irq", 8'(irq_o), 8'd0);
        check("R1 result", 8'(res_valid_o), 8'd0);
        check("R1 accept", 8'(cmd_accept_o), 8'd0);
    endtask

    task automatic t_recal0;
        seek_evt(2'd0, 1'b0, 1'b1, 1'b0, 8'h44);
        check("R5 irq raised", 8'(irq_o), 8'd1);
        sense_two("R2 recal drive0", 8'h20, 8'h00);
        check("R5 irq cleared", 8'(irq_o), 8'd0);
    endtask

    task automatic t_ready;
        ready_evt(1);
        sense_two("R4 ready drive1", 8'hC1, 8'h00);
        @(negedge clk); rdy_i[0] = 1'b0;
        ready_evt(0);
        sense_two("R4 not ready drive0", 8'hC8, 8'h00);
        rdy_i = '1;
    endtask

    task automatic t_seek;
        seek_evt(2'd2, 1'b0, 1'b0, 1'b1, 8'h35);
        sense_two("R10 seek drive2 head1", 8'h26, 8'h35);
        @(negedge clk); rdy_i[0] = 1'b0;
        seek_evt(2'd0, 1'b0, 1'b0, 1'b0, 8'h12);
        sense_two("R10 seek drive0 not ready", 8'h28, 8'h12);
        rdy_i = '1;
    endtask

    task automatic t_fail;
        seek_evt(2'd3, 1'b1, 1'b0, 1'b0, 8'h10);
        sense_two("R3 failed seek drive3", 8'h63, 8'h10);
    endtask

    task automatic t_multi;
        seek_evt(2'd3, 1'b0, 1'b0, 1'b0, 8'h07);
        ready_evt(1);
        sense_two("R6 lowest first", 8'hC1, 8'h00);
        check("R6 other still pending", 8'(irq_o), 8'd1);
        sense_two("R6 remaining drive3", 8'h23, 8'h07);
        check("R5 irq low after last", 8'(irq_o), 8'd0);
    endtask

    task automatic t_empty;
        single_invalid("R7 empty sense", SENSE);
    endtask

    task automatic t_lock;
        seek_evt(2'd2, 1'b0, 1'b1, 1'b0, 8'h00);
        single_invalid("R8 locked command", OTHER);
        check("R8 irq kept", 8'(irq_o), 8'd1);
        single_invalid("R8 lock persists", OTHER);
        sense_two("R8 sense after lock", 8'h22, 8'h00);
        issue(OTHER);
        check("R9 accept pulse", 8'(cmd_accept_o), 8'd1);
        check("R9 no result", 8'(res_valid_o), 8'd0);
        @(negedge clk);
        check("R9 pulse one cycle", 8'(cmd_accept_o), 8'd0);
    endtask

    task automatic t_resp;
        seek_evt(2'd1, 1'b0, 1'b1, 1'b0, 8'h00);
        seek_evt(2'd2, 1'b0, 1'b1, 1'b0, 8'h00);
        @(negedge clk);
        cmd_valid_i = 1'b1; cmd_op_i = SENSE;
        @(negedge clk);
        check("R11 byte0 next cycle", res_data_o, 8'h21);
        @(negedge clk);
        cmd_valid_i = 1'b0;
        check("R11 byte1 last", 8'(res_last_o), 8'd1);
        check("R11 byte1 cylinder", res_data_o, 8'h00);
        @(negedge clk);
        check("R11 extra command ignored", 8'(res_valid_o), 8'd0);
        check("R11 drive2 still pending", 8'(irq_o), 8'd1);
        sense_two("R11 drive2 next", 8'h22, 8'h00);
    endtask

    task automatic t_reset_lock;
        seek_evt(2'd0, 1'b0, 1'b0, 1'b0, 8'h09);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        check("R1 reset clears pending", 8'(irq_o), 8'd0);
        issue(OTHER);
        check("R1 reset clears lock", 8'(cmd_accept_o), 8'd1);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_recal0();
        t_ready();
        t_seek();
        t_fail();
        t_multi();
        t_empty();
        t_lock();
        t_resp();
        t_reset_lock();
        repeat (2) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule